// File: doc/BRIEF.md
# Stall-Only Read-After-Write Hazard Detector

This block is the interlock of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no bypass paths. Each cycle it compares the two source register numbers of the instruction sitting in decode against the destination register of each older instruction still in flight. Those older instructions sit in the decode/execute, execute/memory and memory/writeback pipeline registers. When a live match is found, the block freezes the program counter and the fetch/decode register and turns the instruction entering execute into a bubble by zeroing its control bits.

The detector is purely combinational and is re-evaluated every cycle. While the consumer waits in decode, the producer keeps moving down the pipeline, so the stall lasts as long as a match remains. A producer one instruction ahead costs three bubbles, two instructions ahead costs two, and three ahead costs one. Each older stage supplies both candidate destination fields (the `rd`-type and `rt`-type slots) and a select bit, and the block picks the real destination before comparing. The parameter `WRITE_THEN_READ` covers a register file that writes in the first half of the cycle and reads in the second. In that case the writeback-stage comparison is dropped, and each distance costs one bubble less.

Top module: `raw_stall_detect`

## Requirements
- R1: A source register equal to the selected decode/execute destination, with that stage's write enable high and the register non-zero, drives `ctrl_flush_o` = 1, `pc_wen_o` = 0 and `ifid_wen_o` = 0.
- R2: The same match against the execute/memory stage also stalls.
- R3: With `WRITE_THEN_READ` = 0, a match against the memory/writeback stage stalls. With `WRITE_THEN_READ` = 1, a match against that stage alone does not stall.
- R4: A stage whose write enable is 0 never causes a stall, whatever its register fields hold.
- R5: The selected destination is `*_rd_i` when `*_use_rd_i` = 1 and `*_rt_i` when it is 0. The unselected field has no effect.
- R6: Register number 0 never causes a stall, as a source or as a destination. A zero match on one source does not hide a real match on the other.
- R7: With no live match, `pc_wen_o` = 1, `ifid_wen_o` = 0b1 and `ctrl_flush_o` = 0. This includes the all-zero input state.
- R8: `pc_wen_o` and `ifid_wen_o` are always equal, and each is the inverse of `ctrl_flush_o`.
- R9: Both source operands are checked. A match on the second source alone stalls.
- R10: A dependent instruction that directly follows its producer stalls 3 cycles as the producer advances, or 2 cycles with `WRITE_THEN_READ` = 1. A producer two instructions ahead costs 2 cycles, or 1 with `WRITE_THEN_READ` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_i | input | REG_AW | First source register of the decode instruction |
| src_b_i | input | REG_AW | Second source register of the decode instruction |
| ex_rt_i | input | REG_AW | Decode/execute stage rt-slot destination |
| ex_rd_i | input | REG_AW | Decode/execute stage rd-slot destination |
| ex_use_rd_i | input | 1 | Decode/execute: 1 selects rd slot, 0 selects rt slot |
| ex_wen_i | input | 1 | Decode/execute register-write enable |
| mem_rt_i | input | REG_AW | Execute/memory stage rt-slot destination |
| mem_rd_i | input | REG_AW | Execute/memory stage rd-slot destination |
| mem_use_rd_i | input | 1 | Execute/memory destination select |
| mem_wen_i | input | 1 | Execute/memory register-write enable |
| wb_rt_i | input | REG_AW | Memory/writeback stage rt-slot destination |
| wb_rd_i | input | REG_AW | Memory/writeback stage rd-slot destination |
| wb_use_rd_i | input | 1 | Memory/writeback destination select |
| wb_wen_i | input | 1 | Memory/writeback register-write enable |
| pc_wen_o | output | 1 | Program counter write enable |
| ifid_wen_o | output | 1 | Fetch/decode register write enable |
| ctrl_flush_o | output | 1 | Zeroes control bits entering decode/execute |

## Verification
The block holds no state, so any fault shows at the outputs in the same cycle as the input pattern that exposes it. A wrong destination select shows up as a stall on the unselected field, or as a missed stall. A missing zero-register or write-enable qualifier shows up as a spurious stall. A wrong stage mask shows up as a stall count off by one in the advancing-producer sequence. The stimulus therefore pairs each matching pattern with a near-miss that differs in only one field.

// File: rtl/hz_pkg.sv
`timescale 1ns/1ps
package hz_pkg;
   localparam int unsigned NUM_PROD = 3;
   typedef enum logic [1:0] {
      PROD_EXE = 2'd0,
      PROD_MEM = 2'd1,
      PROD_WB  = 2'd2
   } prod_stage_e;

   function automatic logic [NUM_PROD-1:0] live_mask(input bit write_then_read);
      logic [NUM_PROD-1:0] m;
      m = '1;
      if (write_then_read) m[PROD_WB] = 1'b0;
      return m;
   endfunction
endpackage

// File: rtl/hz_dest_sel.sv
`timescale 1ns/1ps
module hz_dest_sel #(
   parameter int unsigned REG_AW = 5
) (
   input  logic [REG_AW-1:0] rt_i,
   input  logic [REG_AW-1:0] rd_i,
   input  logic              use_rd_i,
   output logic [REG_AW-1:0] dst_o
);
   always_comb dst_o = use_rd_i ? rd_i : rt_i;
endmodule

// File: rtl/hz_src_cmp.sv
`timescale 1ns/1ps
module hz_src_cmp #(
   parameter int unsigned REG_AW  = 5,
   parameter int unsigned NUM_SRC = 2
) (
   input  logic [NUM_SRC-1:0][REG_AW-1:0] src_i,
   input  logic [REG_AW-1:0]              dst_i,
   input  logic                           wen_i,
   output logic                           hit_o
);
   logic [NUM_SRC-1:0] eq;
   logic               dst_live;

   assign dst_live = wen_i && (dst_i != '0);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign eq[i] = (src_i[i] == dst_i);
   end

   assign hit_o = dst_live && (|eq);
endmodule

// File: rtl/raw_stall_detect.sv
`timescale 1ns/1ps
module raw_stall_detect
   import hz_pkg::*;
#(
   parameter int unsigned REG_AW          = 5,
   parameter bit          WRITE_THEN_READ = 1'b0
) (
   input  logic [REG_AW-1:0] src_a_i,
   input  logic [REG_AW-1:0] src_b_i,
   input  logic [REG_AW-1:0] ex_rt_i,
   input  logic [REG_AW-1:0] ex_rd_i,
   input  logic              ex_use_rd_i,
   input  logic              ex_wen_i,
   input  logic [REG_AW-1:0] mem_rt_i,
   input  logic [REG_AW-1:0] mem_rd_i,
   input  logic              mem_use_rd_i,
   input  logic              mem_wen_i,
   input  logic [REG_AW-1:0] wb_rt_i,
   input  logic [REG_AW-1:0] wb_rd_i,
   input  logic              wb_use_rd_i,
   input  logic              wb_wen_i,
   output logic              pc_wen_o,
   output logic              ifid_wen_o,
   output logic              ctrl_flush_o
);
   localparam int unsigned       NSRC     = 2;
   localparam logic [NUM_PROD-1:0] PROD_EN = live_mask(WRITE_THEN_READ);

   if (REG_AW < 2 || REG_AW > 8) begin : g_bad_aw
      $error("raw_stall_detect: REG_AW must lie in 2..8");
   end

   logic [NSRC-1:0][REG_AW-1:0]     srcs;
   logic [NUM_PROD-1:0][REG_AW-1:0] p_rt, p_rd, p_dst;
   logic [NUM_PROD-1:0]             p_sel, p_wen, p_hit;
   logic                            stall;

   assign srcs = {src_b_i, src_a_i};

   assign p_rt  = {wb_rt_i, mem_rt_i, ex_rt_i};
   assign p_rd  = {wb_rd_i, mem_rd_i, ex_rd_i};
   assign p_sel = {wb_use_rd_i, mem_use_rd_i, ex_use_rd_i};
   assign p_wen = {wb_wen_i, mem_wen_i, ex_wen_i};

   for (genvar s = 0; s < NUM_PROD; s++) begin : g_prod
      hz_dest_sel #(.REG_AW(REG_AW)) u_sel (
         .rt_i     (p_rt[s]),
         .rd_i     (p_rd[s]),
         .use_rd_i (p_sel[s]),
         .dst_o    (p_dst[s])
      );
      hz_src_cmp #(.REG_AW(REG_AW), .NUM_SRC(NSRC)) u_cmp (
         .src_i (srcs),
         .dst_i (p_dst[s]),
         .wen_i (p_wen[s]),
         .hit_o (p_hit[s])
      );
   end

   assign stall        = |(p_hit & PROD_EN);
   assign ctrl_flush_o = stall;
   assign pc_wen_o     = ~stall;
   assign ifid_wen_o   = ~stall;

   // Port-level checks, computed apart from the submodules.
   always_comb begin : chk
      logic [REG_AW-1:0] de, dm, dw;
      de = ex_use_rd_i  ? ex_rd_i  : ex_rt_i;
      dm = mem_use_rd_i ? mem_rd_i : mem_rt_i;
      dw = wb_use_rd_i  ? wb_rd_i  : wb_rt_i;
      if (ex_wen_i && de != '0 && (de == src_a_i || de == src_b_i))
         p_idex_hit_r1: assert (ctrl_flush_o && !pc_wen_o);
      if (mem_wen_i && dm != '0 && (dm == src_a_i || dm == src_b_i))
         p_exmem_hit_r2: assert (ctrl_flush_o && !ifid_wen_o);
      if (!WRITE_THEN_READ && wb_wen_i && dw != '0 && (dw == src_a_i || dw == src_b_i))
         p_memwb_hit_r3: assert (ctrl_flush_o);
      if (WRITE_THEN_READ && !ex_wen_i && !mem_wen_i)
         p_memwb_free_r3: assert (!ctrl_flush_o);
      if (!ex_wen_i && !mem_wen_i && !wb_wen_i)
         p_no_writer_r4: assert (!ctrl_flush_o && pc_wen_o);
      if (src_a_i == '0 && src_b_i == '0)
         p_zero_src_r6: assert (!ctrl_flush_o);
   end
endmodule

// File: tb/sim_raw_stall_detect.sv
`timescale 1ns/1ps
module sim_raw_stall_detect;
   localparam int AW = 5;
   localparam int NV = 12;
   // a b | ex rt rd sel wen | mem rt rd sel wen | wb rt rd sel wen | exp(wtr0) exp(wtr1)
   localparam logic [47:0] VEC [NV] = '{
      {5'd1,5'd2,  5'd3,5'd4,1'b1,1'b1,  5'd5,5'd6,1'b1,1'b1,  5'd0,5'd7,1'b1,1'b1,  1'b0,1'b0},
      {5'd4,5'd2,  5'd0,5'd4,1'b1,1'b1,  5'd0,5'd0,1'b0,1'b0,  5'd0,5'd0,1'b0,1'b0,  1'b1,1'b1},
      {5'd1,5'd4,  5'd0,5'd4,1'b1,1'b1,  5'd0,5'd0,1'b0,1'b0,  5'd0,5'd0,1'b0,1'b0,  1'b1,1'b1},
      {5'd6,5'd9,  5'd0,5'd0,1'b0,1'b0,  5'd0,5'd6,1'b1,1'b1,  5'd0,5'd0,1'b0,1'b0,  1'b1,1'b1},
      {5'd7,5'd9,  5'd0,5'd0,1'b0,1'b0,  5'd0,5'd0,1'b0,1'b0,  5'd0,5'd7,1'b1,1'b1,  1'b1,1'b0},
      {5'd4,5'd6,  5'd0,5'd4,1'b1,1'b0,  5'd0,5'd6,1'b1,1'b0,  5'd0,5'd4,1'b1,1'b0,  1'b0,1'b0},
      {5'd3,5'd8,  5'd3,5'd4,1'b1,1'b1,  5'd0,5'd0,1'b0,1'b0,  5'd0,5'd0,1'b0,1'b0,  1'b0,1'b0},
      {5'd3,5'd8,  5'd3,5'd4,1'b0,1'b1,  5'd0,5'd0,1'b0,1'b0,  5'd0,5'd0,1'b0,1'b0,  1'b1,1'b1},
      {5'd4,5'd8,  5'd3,5'd4,1'b0,1'b1,  5'd0,5'd0,1'b0,1'b0,  5'd0,5'd0,1'b0,1'b0,  1'b0,1'b0},
      {5'd0,5'd0,  5'd0,5'd0,1'b1,1'b1,  5'd0,5'd0,1'b0,1'b1,  5'd0,5'd0,1'b1,1'b1,  1'b0,1'b0},
      {5'd0,5'd5,  5'd0,5'd0,1'b1,1'b1,  5'd0,5'd5,1'b1,1'b1,  5'd0,5'd0,1'b0,1'b0,  1'b1,1'b1},
      {5'd2,5'd11, 5'd0,5'd0,1'b0,1'b0,  5'd0,5'd0,1'b0,1'b0,  5'd11,5'd3,1'b0,1'b1, 1'b1,1'b0}
   };
   localparam string VREQ [NV] = '{"R7","R1","R9","R2","R3","R4","R5","R5","R5","R6","R6","R3"};

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [AW-1:0] sa, sb, ert, erd, mrt, mrd, wrt, wrd;
   logic          esel, ewen, msel, mwen, wsel, wwen;
   logic          pc0, if0, fl0, pc1, if1, fl1;
   int            checks = 0, errors = 0;
   bit            done = 1'b0;

   raw_stall_detect #(.REG_AW(AW), .WRITE_THEN_READ(1'b0)) u0 (
      .src_a_i(sa), .src_b_i(sb),
      .ex_rt_i(ert), .ex_rd_i(erd), .ex_use_rd_i(esel), .ex_wen_i(ewen),
      .mem_rt_i(mrt), .mem_rd_i(mrd), .mem_use_rd_i(msel), .mem_wen_i(mwen),
      .wb_rt_i(wrt), .wb_rd_i(wrd), .wb_use_rd_i(wsel), .wb_wen_i(wwen),
      .pc_wen_o(pc0), .ifid_wen_o(if0), .ctrl_flush_o(fl0));

   raw_stall_detect #(.REG_AW(AW), .WRITE_THEN_READ(1'b1)) u1 (
      .src_a_i(sa), .src_b_i(sb),
      .ex_rt_i(ert), .ex_rd_i(erd), .ex_use_rd_i(esel), .ex_wen_i(ewen),
      .mem_rt_i(mrt), .mem_rd_i(mrd), .mem_use_rd_i(msel), .mem_wen_i(mwen),
      .wb_rt_i(wrt), .wb_rd_i(wrd), .wb_use_rd_i(wsel), .wb_wen_i(wwen),
      .pc_wen_o(pc1), .ifid_wen_o(if1), .ctrl_flush_o(fl1));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_outs(input string req, input logic exp0, input logic exp1);
      chk(req, "flush wtr0", int'(fl0), int'(exp0));
      chk(req, "flush wtr1", int'(fl1), int'(exp1));
      chk("R8", "pc_wen wtr0", int'(pc0), int'(!exp0));
      chk("R8", "ifid_wen wtr0", int'(if0), int'(!exp0));
      chk("R8", "pc_wen wtr1", int'(pc1), int'(!exp1));
      chk("R8", "ifid_wen wtr1", int'(if1), int'(!exp1));
   endtask

   task automatic clear_all();
      {sa, sb, ert, erd, mrt, mrd, wrt, wrd} = '0;
      {esel, ewen, msel, mwen, wsel, wwen} = '0;
   endtask

   // Producer of register 9 (rd slot) at pipeline position pos: 0 ex, 1 mem, 2 wb, 3 retired.
   task automatic place_producer(input int pos);
      clear_all();
      sa = 5'd9; sb = 5'd1;
      case (pos)
         0: begin erd = 5'd9; esel = 1'b1; ewen = 1'b1; end
         1: begin mrd = 5'd9; msel = 1'b1; mwen = 1'b1; end
         2: begin wrd = 5'd9; wsel = 1'b1; wwen = 1'b1; end
         default: ;
      endcase
   endtask

   task automatic run_seq(input int start, input int exp0, input int exp1);
      int n0 = 0, n1 = 0;
      for (int p = start; p <= 3; p++) begin
         @(negedge clk);
         place_producer(p);
         #5;
         n0 += int'(fl0);
         n1 += int'(fl1);
      end
      chk("R10", $sformatf("bubbles from stage %0d wtr0", start), n0, exp0);
      chk("R10", $sformatf("bubbles from stage %0d wtr1", start), n1, exp1);
   endtask

   initial begin
      clear_all();
      #5;
      chk_outs("R7", 1'b0, 1'b0); // all-zero inputs
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {sa, sb, ert, erd, esel, ewen, mrt, mrd, msel, mwen, wrt, wrd, wsel, wwen} = VEC[i][47:2];
         #5;
         chk_outs(VREQ[i], VEC[i][1], VEC[i][0]);
      end
      // R5: unselected rt field on writeback stage ignored
      @(negedge clk);
      clear_all(); sa = 5'd12; wrt = 5'd12; wrd = 5'd13; wsel = 1'b1; wwen = 1'b1;
      #5;
      chk_outs("R5", 1'b0, 1'b0);
      // R4: disabled execute/memory writer with matching fields
      @(negedge clk);
      clear_all(); sb = 5'd31; mrt = 5'd31; msel = 1'b0; mwen = 1'b0;
      #5;
      chk_outs("R4", 1'b0, 1'b0);
      run_seq(0, 3, 2);
      run_seq(1, 2, 1);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule